// File: doc/BRIEF.md
# LIN Master Header Generator

This block drives the header of a LIN frame from the master side onto a single serial transmit line. One header command produces, in sequence, a long dominant break, an idle gap, the sync byte, a second idle gap, and the protected identifier byte. Software picks the break length and the gap lengths through two 2-bit codes and supplies a 6-bit identifier. The block forms the two parity bits of the identifier on its own.

All timing is counted in bit times. A one-cycle `bitTick` pulse from an external baud-rate generator marks each bit boundary, so the block runs at any bit rate without change. A second command, the plain request, sends the sync byte and the identifier byte back to back with no break and no gaps. The header command is accepted only while the interface is in LIN master framing mode. While a transfer is in flight the block holds `busy` high, and it pulses `done` once when the transfer ends.

Top module: `lin_hdr_gen`

## Requirements
- R1: The break holds the line low for 13, 17, 21 or 26 bit times for break codes 0, 1, 2 and 3.
- R2: After a header break, the line stays high for 1, 4, 8 or 14 bit times for delay codes 0, 1, 2 and 3, and then the sync start bit begins.
- R3: Between the sync stop bit and the identifier start bit, a header command leaves the line high for 1 bit time with delay code 0 and for 4 bit times with delay codes 1, 2 and 3.
- R4: A header command in a cycle where `linMaster` is 0 is ignored: `busy` stays low and the line stays high.
- R5: A plain request (`plainCmd`) is accepted in any mode. It sends the sync byte and then the identifier byte with no break and no gap between them. If both commands arrive together in LIN master mode, the header command wins.
- R6: Every byte is sent as a low start bit, eight data bits with the least significant bit first, and a high stop bit. The sync byte is 0x55.
- R7: The identifier byte holds ID[5:0] in bits 5:0. Bit 6 is ID0^ID1^ID2^ID4. Bit 7 is the inverse of ID1^ID3^ID4^ID5.
- R8: The line is high while idle and during gaps, and it changes only on the clock edge that ends a cycle in which `bitTick` is 1.
- R9: `busy` rises in the cycle after a command is accepted. It falls in the cycle after the tick that ends the identifier stop bit. `done` is high for exactly that one cycle, and never while `busy` is high.
- R10: The break code, the delay code and the identifier are sampled when the command is accepted. Changes to these inputs later have no effect on the transfer in progress.
- R11: A command of either kind that arrives while `busy` is high is dropped. It does not start a new transfer afterwards.
- R12: After acceptance the line stays high until the first `bitTick`. The first field begins at that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitTick | input | 1 | One-cycle pulse marking each bit boundary |
| linMaster | input | 1 | High when the interface is in LIN master framing mode |
| hdrCmd | input | 1 | Header command: break, gaps, sync and identifier |
| plainCmd | input | 1 | Plain request: sync and identifier only, no gaps |
| brkCode | input | 2 | Break length code |
| dlyCode | input | 2 | Inter-field delay code |
| idIn | input | 6 | Frame identifier |
| txOut | output | 1 | Serial transmit line, high when idle |
| busy | output | 1 | High while a transfer is in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |

## Verification
A wrong sequencer state shows up on `txOut` within one bit time. A field that is too long or too short moves every later bit, so the whole captured stream no longer matches and its length differs. A counter or limit that was latched wrongly shows up as a break or gap of the wrong width. A fault in the shift register or the parity logic corrupts the identifier byte within its ten bits. An error in the end-of-transfer handling shows up in the single cycle where `busy` falls: `done` is either missing there, or it appears in some other cycle.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

  localparam int CNT_W      = 5;
  localparam int ID_W       = 6;
  localparam int BYTE_W     = 8;
  localparam int FRAME_W    = BYTE_W + 2;
  localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'h55;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_BRK, ST_GAP1, ST_SYNC, ST_GAP2, ST_PID
  } hdrState_e;

  typedef enum logic [1:0] {
    LINE_HIGH, LINE_LOW, LINE_SHIFT
  } lineSel_e;

  typedef struct packed {
    logic     accept;
    logic     cntClr;
    logic     cntInc;
    logic     loadSync;
    logic     loadPid;
    logic     shift;
    lineSel_e lineSel;
  } dpStrobe_t;

  function automatic logic [CNT_W-1:0] brkBits(input logic [1:0] code);
    case (code)
      2'd0:    brkBits = CNT_W'(13);
      2'd1:    brkBits = CNT_W'(17);
      2'd2:    brkBits = CNT_W'(21);
      default: brkBits = CNT_W'(26);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] gapPreSync(input logic [1:0] code);
    case (code)
      2'd0:    gapPreSync = CNT_W'(1);
      2'd1:    gapPreSync = CNT_W'(4);
      2'd2:    gapPreSync = CNT_W'(8);
      default: gapPreSync = CNT_W'(14);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] gapPreId(input logic [1:0] code);
    gapPreId = (code == 2'd0) ? CNT_W'(1) : CNT_W'(4);
  endfunction

  function automatic logic [BYTE_W-1:0] protectId(input logic [ID_W-1:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    protectId = {p1, p0, id};
  endfunction

endpackage

// File: rtl/lin_hdr_ctrl.sv
module lin_hdr_ctrl
  import lin_hdr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             linMaster,
  input  logic             hdrCmd,
  input  logic             plainCmd,
  input  logic [1:0]       brkCode,
  input  logic [1:0]       dlyCode,
  input  logic [CNT_W-1:0] cnt,
  output dpStrobe_t        stb,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(FRAME_W - 1);

  hdrState_e        state, stateNext;
  logic [CNT_W-1:0] brkLim, gap1Lim, gap2Lim, curLim;
  logic             plainRun;
  logic             takeHdr, takePlain, fieldEnd, doneNext;

  assign takeHdr   = (state == ST_IDLE) && hdrCmd && linMaster;
  assign takePlain = (state == ST_IDLE) && plainCmd && !takeHdr;

  always_comb begin
    case (state)
      ST_BRK:  curLim = brkLim;
      ST_GAP1: curLim = gap1Lim;
      ST_GAP2: curLim = gap2Lim;
      default: curLim = BYTE_LAST + CNT_W'(1);
    endcase
  end

  assign fieldEnd = bitTick && (cnt == curLim - CNT_W'(1));

  always_comb begin
    stb       = '0;
    stb.lineSel = LINE_HIGH;
    stateNext = state;
    doneNext  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (takeHdr || takePlain) begin
          stb.accept = 1'b1;
          stateNext  = ST_ARM;
        end
      end
      ST_ARM: begin
        if (bitTick) begin
          stb.cntClr = 1'b1;
          if (plainRun) begin
            stb.loadSync = 1'b1;
            stateNext    = ST_SYNC;
          end else begin
            stateNext = ST_BRK;
          end
        end
      end
      ST_BRK: begin
        stb.lineSel = LINE_LOW;
        if (fieldEnd) begin
          stb.cntClr = 1'b1;
          stateNext  = ST_GAP1;
        end else if (bitTick) begin
          stb.cntInc = 1'b1;
        end
      end
      ST_GAP1: begin
        if (fieldEnd) begin
          stb.cntClr   = 1'b1;
          stb.loadSync = 1'b1;
          stateNext    = ST_SYNC;
        end else if (bitTick) begin
          stb.cntInc = 1'b1;
        end
      end
      ST_SYNC: begin
        stb.lineSel = LINE_SHIFT;
        if (fieldEnd) begin
          stb.cntClr = 1'b1;
          if (plainRun) begin
            stb.loadPid = 1'b1;
            stateNext   = ST_PID;
          end else begin
            stateNext = ST_GAP2;
          end
        end else if (bitTick) begin
          stb.cntInc = 1'b1;
          stb.shift  = 1'b1;
        end
      end
      ST_GAP2: begin
        if (fieldEnd) begin
          stb.cntClr  = 1'b1;
          stb.loadPid = 1'b1;
          stateNext   = ST_PID;
        end else if (bitTick) begin
          stb.cntInc = 1'b1;
        end
      end
      ST_PID: begin
        stb.lineSel = LINE_SHIFT;
        if (fieldEnd) begin
          stb.cntClr = 1'b1;
          doneNext   = 1'b1;
          stateNext  = ST_IDLE;
        end else if (bitTick) begin
          stb.cntInc = 1'b1;
          stb.shift  = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      brkLim   <= CNT_W'(13);
      gap1Lim  <= CNT_W'(1);
      gap2Lim  <= CNT_W'(1);
      plainRun <= 1'b0;
      done     <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
      if (stb.accept) begin
        plainRun <= takePlain;
        brkLim   <= brkBits(brkCode);
        gap1Lim  <= gapPreSync(dlyCode);
        gap2Lim  <= gapPreId(dlyCode);
      end
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/lin_hdr_dp.sv
module lin_hdr_dp
  import lin_hdr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [ID_W-1:0]  idIn,
  output logic [CNT_W-1:0] cnt,
  output logic             txOut
);

  logic [BYTE_W-1:0]  pidReg;
  logic [FRAME_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pidReg <= '0;
      shReg  <= '1;
      cnt    <= '0;
    end else begin
      if (stb.accept) begin
        pidReg <= protectId(idIn);
      end
      if (stb.loadSync) begin
        shReg <= {1'b1, SYNC_BYTE, 1'b0};
      end else if (stb.loadPid) begin
        shReg <= {1'b1, pidReg, 1'b0};
      end else if (stb.shift) begin
        shReg <= {1'b1, shReg[FRAME_W-1:1]};
      end
      if (stb.cntClr) begin
        cnt <= '0;
      end else if (stb.cntInc) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    case (stb.lineSel)
      LINE_LOW:   txOut = 1'b0;
      LINE_SHIFT: txOut = shReg[0];
      default:    txOut = 1'b1;
    endcase
  end

endmodule

// File: rtl/lin_hdr_gen.sv
module lin_hdr_gen
  import lin_hdr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  logic        linMaster,
  input  logic        hdrCmd,
  input  logic        plainCmd,
  input  logic [1:0]  brkCode,
  input  logic [1:0]  dlyCode,
  input  logic [5:0]  idIn,
  output logic        txOut,
  output logic        busy,
  output logic        done
);

  dpStrobe_t        stb;
  logic [CNT_W-1:0] cnt;

  lin_hdr_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .bitTick   (bitTick),
    .linMaster (linMaster),
    .hdrCmd    (hdrCmd),
    .plainCmd  (plainCmd),
    .brkCode   (brkCode),
    .dlyCode   (dlyCode),
    .cnt       (cnt),
    .stb       (stb),
    .busy      (busy),
    .done      (done)
  );

  lin_hdr_dp dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .idIn  (idIn),
    .cnt   (cnt),
    .txOut (txOut)
  );

endmodule

// File: rtl/lin_hdr_chk.sv
module lin_hdr_chk (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic linMaster,
  input logic hdrCmd,
  input logic plainCmd,
  input logic txOut,
  input logic busy,
  input logic done
);

  // R9: the end pulse never overlaps an active transfer
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9: the end pulse lasts a single cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: the end pulse only follows a busy cycle
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  // R8: the line is high whenever no transfer runs
  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut);

  // R8: the line moves only on tick edges
  a_r8_tick_paced: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(txOut));

  // R4: header command outside LIN master mode starts nothing
  a_r4_mode_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && hdrCmd && !linMaster && !plainCmd) |=> !busy);

  // R11: a transfer ends only through the end pulse
  a_r11_no_retrigger: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

endmodule

bind lin_hdr_gen lin_hdr_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .bitTick   (bitTick),
  .linMaster (linMaster),
  .hdrCmd    (hdrCmd),
  .plainCmd  (plainCmd),
  .txOut     (txOut),
  .busy      (busy),
  .done      (done)
);

// File: tb/lin_hdr_gen_tb_top.sv
module lin_hdr_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int MAXB       = 96;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0;
  logic       linMaster = 1'b0;
  logic       hdrCmd = 1'b0;
  logic       plainCmd = 1'b0;
  logic [1:0] brkCode = 2'd0;
  logic [1:0] dlyCode = 2'd0;
  logic [5:0] idIn = 6'd0;
  logic       txOut, busy, done;

  int  errCnt = 0;
  int  chkCnt = 0;
  bit  finished = 1'b0;
  bit  expBits [MAXB];
  bit  capBits [MAXB];
  int  expN, capN;

  lin_hdr_gen dut_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .linMaster(linMaster),
    .hdrCmd(hdrCmd), .plainCmd(plainCmd), .brkCode(brkCode),
    .dlyCode(dlyCode), .idIn(idIn), .txOut(txOut), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chkCnt++;
    errCnt++;
    $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", WATCHDOG);
    summary();
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int brkLen(input logic [1:0] c);
    int t [4] = '{13, 17, 21, 26};
    return t[c];
  endfunction

  function automatic int gap1Len(input logic [1:0] c);
    int t [4] = '{1, 4, 8, 14};
    return t[c];
  endfunction

  function automatic int gap2Len(input logic [1:0] c);
    return (c == 2'd0) ? 1 : 4;
  endfunction

  function automatic logic [7:0] pidOf(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = !(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  task automatic pushBits(input bit v, input int n);
    for (int i = 0; i < n; i++) begin
      expBits[expN] = v;
      expN++;
    end
  endtask

  task automatic pushByte(input logic [7:0] b);
    pushBits(1'b0, 1);
    for (int i = 0; i < 8; i++) pushBits(b[i], 1);
    pushBits(1'b1, 1);
  endtask

  // R12: one high bit-time before the first field
  task automatic buildExp(input bit isHdr, input logic [1:0] b, input logic [1:0] d,
                          input logic [5:0] id);
    expN = 0;
    pushBits(1'b1, 1);
    if (isHdr) begin
      pushBits(1'b0, brkLen(b));
      pushBits(1'b1, gap1Len(d));
    end
    pushByte(8'h55);
    if (isHdr) pushBits(1'b1, gap2Len(d));
    pushByte(pidOf(id));
  endtask

  task automatic runFrame(input bit hdrC, input bit plainC, input bit mode,
                          input logic [1:0] b, input logic [1:0] d,
                          input logic [5:0] id, input bit disturb);
    bit prevBusy, prevTx, lastTick, stabBad, doneBad, doneSeen, matchOk;
    int guard, firstBad;
    buildExp(hdrC && mode, b, d, id);
    @(negedge clk);
    hdrCmd = hdrC; plainCmd = plainC; linMaster = mode;
    brkCode = b; dlyCode = d; idIn = id; bitTick = 1'b0;
    capN = 0; prevBusy = 1'b0; prevTx = 1'b1; lastTick = 1'b0;
    stabBad = 1'b0; doneBad = 1'b0; doneSeen = 1'b0;
    guard = 0;
    while (guard < 5000) begin
      @(negedge clk);
      guard++;
      hdrCmd = 1'b0; plainCmd = 1'b0;
      if (disturb && capN == 20) begin
        hdrCmd = 1'b1; plainCmd = 1'b1;
        brkCode = ~b; dlyCode = ~d; idIn = ~id;
      end
      if (prevBusy && !busy) begin
        doneSeen = done;
        break;
      end
      if (busy && done) doneBad = 1'b1;
      if (busy && !lastTick && txOut != prevTx) stabBad = 1'b1;
      bitTick = ($urandom_range(0, 2) == 0);
      if (busy && bitTick && capN < MAXB) begin
        capBits[capN] = txOut;
        capN++;
      end
      prevBusy = busy; prevTx = txOut; lastTick = bitTick;
    end
    bitTick = 1'b0;
    hdrCmd = 1'b0; plainCmd = 1'b0;
    matchOk = (capN == expN);
    firstBad = -1;
    for (int i = 0; i < expN && i < capN; i++) begin
      if (capBits[i] != expBits[i] && firstBad < 0) begin
        firstBad = i;
        matchOk = 1'b0;
      end
    end
    // R1 R2 R3 R5 R6 R7 R10 R12: whole bit stream and its length
    check(matchOk, "R1/R2/R3/R5/R6/R7/R10/R12 bit stream length",
          capN, expN);
    if (firstBad >= 0)
      $display("  first differing bit index %0d", firstBad);
    // R9: end pulse in the cycle busy falls, none while busy
    check(doneSeen && !doneBad, "R9 done pulse at end", int'(doneSeen), 1);
    // R8: line only moved after tick cycles
    check(!stabBad, "R8 line paced by tick", int'(stabBad), 0);
    if (disturb) begin
      bit restarted = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (busy) restarted = 1'b1;
        bitTick = ($urandom_range(0, 2) == 0);
      end
      bitTick = 1'b0;
      // R11: command seen while busy was dropped
      check(!restarted, "R11 no transfer after busy-time command", int'(restarted), 0);
    end
  endtask

  task automatic runIgnored();
    bit bad = 1'b0;
    @(negedge clk);
    hdrCmd = 1'b1; plainCmd = 1'b0; linMaster = 1'b0;
    brkCode = 2'd1; dlyCode = 2'd2; idIn = 6'h2A;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      hdrCmd = 1'b0;
      if (busy || !txOut) bad = 1'b1;
      bitTick = ($urandom_range(0, 2) == 0);
    end
    bitTick = 1'b0;
    // R4: header command outside LIN master mode
    check(!bad, "R4 header ignored outside master mode", int'(bad), 0);
  endtask

  initial begin
    int seedInit;
    seedInit = $urandom(32'd24681);
    repeat (4) @(negedge clk);
    // reset values
    check(txOut == 1'b1 && busy == 1'b0 && done == 1'b0, "R8/R9 reset state",
          int'({txOut, busy, done}), 4);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int c = 0; c < 4; c++)
      runFrame(1'b1, 1'b0, 1'b1, 2'(c), 2'(c), 6'(c * 13 + 5), 1'b0);
    runFrame(1'b1, 1'b0, 1'b1, 2'd3, 2'd0, 6'h3F, 1'b0);
    runFrame(1'b1, 1'b0, 1'b1, 2'd0, 2'd3, 6'h00, 1'b0);
    // R5: plain request in both modes, and precedence
    runFrame(1'b0, 1'b1, 1'b0, 2'd2, 2'd2, 6'h15, 1'b0);
    runFrame(1'b0, 1'b1, 1'b1, 2'd1, 2'd3, 6'h2A, 1'b0);
    runFrame(1'b1, 1'b1, 1'b1, 2'd1, 2'd1, 6'h31, 1'b0);
    runIgnored();
    // R10 R11: input changes and new commands while busy
    runFrame(1'b1, 1'b0, 1'b1, 2'd2, 2'd1, 6'h0B, 1'b1);

    for (int n = 0; n < 12; n++) begin
      logic [1:0] rb, rd;
      logic [5:0] ri;
      bit rh;
      rb = 2'($urandom_range(0, 3));
      rd = 2'($urandom_range(0, 3));
      ri = 6'($urandom_range(0, 63));
      rh = ($urandom_range(0, 3) != 0);
      runFrame(rh, !rh, 1'b1, rb, rd, ri, ($urandom_range(0, 3) == 0) && rh);
    end
    repeat (3) @(negedge clk);
    summary();
  end

endmodule